// File: doc/BRIEF.md
# Unaligned Byte Write Packer

The packer turns a byte-granular write request into a series of aligned 32-bit word writes for a flash programming engine. A request carries a byte start address and a byte count. The payload then arrives one byte at a time on a valid/ready stream. The block gathers the bytes into byte lanes. Each completed word goes out on a valid/ready word port together with its aligned address. The engine answers every word with a success flag.

In a partial word, every lane that holds no payload is filled with 0xFF. Programming flash can only clear bits, so an all-ones lane leaves the stored byte as it was, and no read-modify-write is needed. When the request ends, the block raises a one-cycle completion pulse. The pulse carries the number of payload bytes that were committed and an error flag. If the engine rejects a word, the packer stops at once and does not issue any further words.

Top module: `byte_wr_packer`

## Requirements
- R1: Every word write carries an address whose low two bits are zero. The first word goes to the start address with those bits cleared, and each later word goes to the previous word address plus 4.
- R2: When the start address is unaligned, the first word holds 0xFF in every lane below the start offset. Payload fills the lanes from that offset upward until the word is full or the payload runs out.
- R3: While 4 or more payload bytes remain after the first word, each word holds 4 payload bytes and no padding.
- R4: A final remainder of 1 to 3 bytes goes out as one word, with the payload in the low lanes and 0xFF in every lane above it.
- R5: The completion count is the number of payload bytes in the words that were accepted with success. Padding lanes are never counted, and the count never exceeds the request length.
- R6: A request of length zero produces no word write. The completion pulse follows in the next cycle with a count of 0 and the error flag clear.
- R7: When a word is answered with failure, the packer issues no further words and accepts no further payload bytes. It raises the completion pulse in the cycle after the response, with the error flag set and the count of bytes committed before the failing word.
- R8: Byte lane 0 is bits 7:0 of the word. Within a word, payload byte order follows increasing lane order.
- R9: Once wr_valid is raised, it stays high and wr_addr and wr_data stay unchanged until wr_ready is seen. No payload byte is accepted from the time a word is offered until its response arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A new request is present |
| req_ready | output | 1 | The packer is idle and takes a request |
| req_addr | input | ADDR_W | Byte start address |
| req_len | input | LEN_W | Byte count |
| in_valid | input | 1 | A payload byte is present |
| in_ready | output | 1 | The packer takes a payload byte |
| in_data | input | 8 | Payload byte |
| wr_valid | output | 1 | A word write is offered |
| wr_ready | input | 1 | The engine takes the word |
| wr_addr | output | ADDR_W | Aligned word address |
| wr_data | output | 32 | Word data, lane 0 in bits 7:0 |
| rsp_valid | input | 1 | Response for the outstanding word |
| rsp_ok | input | 1 | The word was programmed successfully |
| done_valid | output | 1 | One-cycle completion pulse |
| done_err | output | 1 | The request ended on a failed word |
| done_count | output | LEN_W | Payload bytes committed |

## Verification
On every cycle the assertions check the following properties. Word addresses must be aligned. The offered word must hold steady under backpressure, and no payload byte may be taken while a word is in flight. A zero-length request must finish in one cycle, and a failure response must be followed at once by an error completion. The reported count must never exceed the request length. The lane contents themselves can only be shown by the bench's scenarios: the padding below the head offset and above the tail, the byte order in each word, the count of payload bytes only, and the number of bytes consumed before a failure. These scenarios sweep every start offset against a range of lengths, with and without stalls, and inject a failure at each word position.

// File: rtl/bwp_pkg.sv
package bwp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FILL  = 3'd1,
        ST_ISSUE = 3'd2,
        ST_WAIT  = 3'd3,
        ST_DONE  = 3'd4
    } pk_state_e;
endpackage

// File: rtl/bwp_lane_insert.sv
module bwp_lane_insert #(
    parameter int LANES = 4,
    localparam int OFS_W = $clog2(LANES),
    localparam int WORD_W = 8 * LANES
) (
    input  logic [WORD_W-1:0] word_in,
    input  logic [OFS_W-1:0]  lane,
    input  logic [7:0]        byte_in,
    output logic [WORD_W-1:0] word_out
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        // lane i occupies bits 8*i+7 : 8*i (R8)
        assign word_out[8*i +: 8] = (lane == OFS_W'(i)) ? byte_in : word_in[8*i +: 8];
    end
endmodule

// File: rtl/byte_wr_packer.sv
module byte_wr_packer #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12,
    parameter int LANES  = 4,
    localparam int OFS_W  = $clog2(LANES),
    localparam int WORD_W = 8 * LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    input  logic              rsp_valid,
    input  logic              rsp_ok,
    output logic              done_valid,
    output logic              done_err,
    output logic [LEN_W-1:0]  done_count
);
    import bwp_pkg::*;

    typedef struct packed {
        pk_state_e         st;
        logic [ADDR_W-1:0] waddr;
        logic [WORD_W-1:0] word;
        logic [OFS_W-1:0]  lane;
        logic [LEN_W-1:0]  left;
        logic [OFS_W:0]    nbytes;
        logic [LEN_W-1:0]  count;
        logic              err;
    } pk_regs_t;

    pk_regs_t r_q, r_d;
    logic [WORD_W-1:0] word_ins;

    bwp_lane_insert #(.LANES(LANES)) u_ins (
        .word_in  (r_q.word),
        .lane     (r_q.lane),
        .byte_in  (in_data),
        .word_out (word_ins)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.count  = '0;
                    r_d.err    = 1'b0;
                    r_d.word   = '1;
                    r_d.nbytes = '0;
                    r_d.left   = req_len;
                    r_d.lane   = req_addr[OFS_W-1:0];
                    r_d.waddr  = {req_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
                    r_d.st     = (req_len == '0) ? ST_DONE : ST_FILL;
                end
            end
            ST_FILL: begin
                if (in_valid) begin
                    r_d.word   = word_ins;
                    r_d.lane   = r_q.lane + 1'b1;
                    r_d.left   = r_q.left - 1'b1;
                    r_d.nbytes = r_q.nbytes + 1'b1;
                    if (r_q.lane == OFS_W'(LANES - 1) || r_q.left == LEN_W'(1))
                        r_d.st = ST_ISSUE;
                end
            end
            ST_ISSUE: begin
                if (wr_ready) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (rsp_valid) begin
                    if (!rsp_ok) begin
                        r_d.err = 1'b1;
                        r_d.st  = ST_DONE;
                    end else begin
                        r_d.count = r_q.count + LEN_W'(r_q.nbytes);
                        if (r_q.left == '0) begin
                            r_d.st = ST_DONE;
                        end else begin
                            r_d.st     = ST_FILL;
                            r_d.lane   = '0;
                            r_d.word   = '1;
                            r_d.nbytes = '0;
                            r_d.waddr  = r_q.waddr + ADDR_W'(LANES);
                        end
                    end
                end
            end
            ST_DONE: r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.waddr  <= '0;
            r_q.word   <= '1;
            r_q.lane   <= '0;
            r_q.left   <= '0;
            r_q.nbytes <= '0;
            r_q.count  <= '0;
            r_q.err    <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready  = (r_q.st == ST_IDLE);
    assign in_ready   = (r_q.st == ST_FILL);
    assign wr_valid   = (r_q.st == ST_ISSUE);
    assign wr_addr    = r_q.waddr;
    assign wr_data    = r_q.word;
    assign done_valid = (r_q.st == ST_DONE);
    assign done_err   = r_q.err;
    assign done_count = r_q.count;
endmodule

// File: rtl/byte_wr_packer_chk.sv
module byte_wr_packer_chk #(
    parameter int ADDR_W = 16,
    parameter int LEN_W  = 12,
    parameter int LANES  = 4,
    localparam int OFS_W  = $clog2(LANES),
    localparam int WORD_W = 8 * LANES
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic [LEN_W-1:0]  req_len,
    input logic              in_valid,
    input logic              in_ready,
    input logic [7:0]        in_data,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [WORD_W-1:0] wr_data,
    input logic              rsp_valid,
    input logic              rsp_ok,
    input logic              done_valid,
    input logic              done_err,
    input logic [LEN_W-1:0]  done_count
);
    logic             pend_q;
    logic [LEN_W-1:0] len_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            len_q  <= '0;
        end else begin
            if (req_valid && req_ready) len_q <= req_len;
            if (wr_valid && wr_ready) pend_q <= 1'b1;
            else if (rsp_valid) pend_q <= 1'b0;
        end
    end

    a_r1_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (wr_addr[OFS_W-1:0] == '0));

    a_r9_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    a_r9_no_byte_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid || pend_q) |-> !in_ready);

    a_r6_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_len == '0) |=> (done_valid && !done_err && done_count == '0));

    a_r7_fail_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && rsp_valid && !rsp_ok) |=> (done_valid && done_err && !wr_valid));

    a_r5_count_within_len: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> (done_count <= len_q));
endmodule

bind byte_wr_packer byte_wr_packer_chk #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANES(LANES)
) u_chk (.*);

// File: tb/byte_wr_packer_bench.sv
module byte_wr_packer_bench;
    localparam int ADDR_W = 16;
    localparam int LEN_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [7:0]        in_data = '0;
    logic              wr_valid;
    logic              wr_ready = 1'b0;
    logic [ADDR_W-1:0] wr_addr;
    logic [31:0]       wr_data;
    logic              rsp_valid = 1'b0;
    logic              rsp_ok = 1'b0;
    logic              done_valid;
    logic              done_err;
    logic [LEN_W-1:0]  done_count;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    byte_wr_packer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .LANES(4)) u_byte_wr_packer (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int seed, int i);
        return 8'((seed + 3 * i + 16) % 239);
    endfunction

    // expected content of word k, counted from the aligned base
    function automatic logic [31:0] exp_word(int off, int len, int k, int seed);
        logic [31:0] w;
        for (int j = 0; j < 4; j++) begin
            int a = 4 * k + j;
            w[8*j +: 8] = (a >= off && a < off + len) ? pat(seed, a - off) : 8'hFF;
        end
        return w;
    endfunction

    function automatic int word_payload(int off, int len, int k);
        int n = 0;
        for (int j = 0; j < 4; j++) begin
            int a = 4 * k + j;
            if (a >= off && a < off + len) n++;
        end
        return n;
    endfunction

    // fail_at < 0: no failure injected
    task automatic run_case(int base, int off, int len, int fail_at, bit stall, int seed);
        int sent = 0, widx = 0, cyc = 0, nwords, exp_cnt, exp_sent;
        bit pend = 0, fin = 0, req_taken = 0;
        nwords = (len == 0) ? 0 : ((off + len - 1) / 4 + 1);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(base + off);
        req_len   = LEN_W'(len);
        while (!fin && cyc < 400) begin
            if (req_taken) req_valid = 1'b0;
            if (req_valid && req_ready) req_taken = 1;
            in_valid = (sent < len) && (!stall || cyc[0]);
            in_data  = pat(seed, sent);
            if (in_valid && in_ready) sent++;
            rsp_valid = 1'b0;
            wr_ready  = 1'b0;
            if (pend) begin
                rsp_valid = 1'b1;
                rsp_ok    = (widx != fail_at);
                widx++;
                pend = 0;
            end else if (wr_valid && (!stall || cyc[1])) begin
                wr_ready = 1'b1;
                pend = 1;
                check(wr_addr == ADDR_W'(base + 4 * widx), "R1 word address", wr_addr, base + 4 * widx);
                check(wr_data == exp_word(off, len, widx, seed),
                      (widx == 0) ? "R2/R8 head word" : (widx == nwords - 1) ? "R4/R8 tail word" : "R3 full word",
                      wr_data, exp_word(off, len, widx, seed));
            end
            if (done_valid) fin = 1;
            cyc++;
            @(negedge clk);
        end
        in_valid = 1'b0; rsp_valid = 1'b0; wr_ready = 1'b0; req_valid = 1'b0;
        check(fin, "R5 completion seen", fin, 1);
        if (fail_at >= 0 && fail_at < nwords) begin
            exp_cnt = 0;
            for (int k = 0; k < fail_at; k++) exp_cnt += word_payload(off, len, k);
            exp_sent = exp_cnt + word_payload(off, len, fail_at);
            check(done_err == 1'b1, "R7 error flag", done_err, 1);
            check(done_count == LEN_W'(exp_cnt), "R7 count before failure", done_count, exp_cnt);
            check(widx == fail_at + 1, "R7 no words after failure", widx, fail_at + 1);
            check(sent == exp_sent, "R7 no bytes after failure", sent, exp_sent);
        end else begin
            check(done_err == 1'b0, "R5 error flag clear", done_err, 0);
            check(done_count == LEN_W'(len), "R5 payload-only count", done_count, len);
            check(widx == nwords, (len == 0) ? "R6 no word writes" : "R3 word count", widx, nwords);
            check(sent == len, "R5 bytes consumed", sent, len);
        end
        repeat (2) @(negedge clk);
        check(!wr_valid && req_ready, "R7 idle after completion", wr_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(req_ready == 1'b1 && !wr_valid && !done_valid && !in_ready, "R9 reset state",
              {req_ready, wr_valid, done_valid, in_ready}, 4'b1000);
        rst_n = 1'b1;
        // R6 zero length: done must be seen one cycle after acceptance
        @(negedge clk);
        req_valid = 1'b1; req_addr = 16'h0203; req_len = '0;
        @(negedge clk);
        req_valid = 1'b0;
        check(done_valid && done_count == '0 && !done_err, "R6 zero-length done next cycle",
              {done_valid, done_err}, 2'b10);
        @(negedge clk);
        check(!done_valid && !wr_valid, "R6 single pulse", done_valid, 0);
        // sweep offsets and lengths, plain and stalled
        for (int s = 0; s < 2; s++)
            for (int off = 0; off < 4; off++)
                for (int len = 0; len < 14; len++)
                    run_case(16'h0100 + 16 * len, off, len, -1, bit'(s), off * 11 + len);
        // failure at each word position
        for (int off = 0; off < 4; off++)
            for (int f = 0; f < 4; f++)
                run_case(16'h0800, off, 11, f, bit'(f & 1), 5 + off + f);
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule